// File: doc/BRIEF.md
# Bit-Reversed Write Address Generator

This block is the effective-address stage of a data address generator. For each access it takes the current value of a 16-bit pointer register, the index of that pointer, the addressing mode, the access size and the direction. From these it forms the byte address sent to memory and the value written back to the pointer. A control word holds a pivot modifier and an enable flag. When a write qualifies, the pointer steps through a radix-2 FFT buffer in bit-reversed order. To do this, the scaled pivot is added with the carry running from high bits toward low bits, in place of the usual +2 or +1 step.

Only word-sized writes qualify, and only in the pre-increment or post-increment indirect mode, through any pointer except the stack pointer. Every other access gets the ordinary linear address and update. Modulo wrap-around is done downstream. This block only tells that logic, through a separate output, whether modulo may act: a qualifying bit-reversed write blocks it. A strobe registered one cycle later marks accesses that update the pointer.

Top module: `brev_agen`

## Requirements
- R1: `brev_act` is 1 exactly when all of these hold: `ctl[15]` = 1, `ptr_sel` is not 4'b1111, `amode` is 1 (post-increment) or 2 (pre-increment), `wr` = 1 and `word_sz` = 1.
- R2: While `brev_act` is 1, `ptr_next` is the reverse-carry sum of `ptr_in` and the byte pivot `{ctl[14:0],1'b0}`. The carry flows from the pivot's bit toward bit 0, and any carry out of bit 0 is dropped. With pivot 8 and a base whose low 5 bits are zero, 16 post-increment writes visit word offsets 0,8,4,12,2,10,6,14,1,9,5,13,3,11,7,15 and then return to the base.
- R3: While `brev_act` is 1, bit 0 of both `ea` and `ptr_next` is 0, even when bit 0 of `ptr_in` is 1.
- R4: In mode 2 (pre-increment), `ea` equals `ptr_next`. In mode 1 (post-increment), `ea` is the old pointer, with bit 0 cleared when `brev_act` is 1.
- R5: Linear behaviour applies when `brev_act` is 0:
  - Modes 1 and 2 step the pointer by +2 for word accesses (`word_sz` = 1) and by +1 for byte accesses.
  - Mode 0 (plain indirect) and mode 3 (indirect with offset) give `ea` = `ptr_in` and `ptr_next` = `ptr_in`.
- R6: With `ptr_sel` = 4'b1111, an otherwise qualifying write gets the linear +2 step.
- R7: Reads, byte accesses, and modes 0 and 3 get linear addresses even when `ctl[15]` = 1.
- R8: `mod_ok` equals `mod_en` when `brev_act` is 0 and is 0 when `brev_act` is 1. This gives bit-reversed writes precedence over modulo addressing.
- R9: While `brev_act` is 1, pointer bits above the pivot's highest set bit (scaled to bytes) pass to `ptr_next` unchanged.
- R10: `wb_stb` is 0 during reset. After a rising clock edge, it is 1 exactly when `acc_en` was 1 and `amode` was 1 or 2 at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | An access is issued this cycle |
| ptr_in | input | 16 | Current pointer register value |
| ptr_sel | input | 4 | Pointer index; 4'b1111 is the stack pointer |
| amode | input | 2 | 0 indirect, 1 post-increment, 2 pre-increment, 3 indirect with offset |
| wr | input | 1 | 1 = write, 0 = read |
| word_sz | input | 1 | 1 = word access, 0 = byte access |
| ctl | input | 16 | Bit 15 enables bit reversal; bits 14:0 hold the pivot in words |
| mod_en | input | 1 | Modulo addressing is configured for this pointer |
| ea | output | 16 | Effective byte address |
| ptr_next | output | 16 | Pointer value to write back |
| brev_act | output | 1 | This access uses bit-reversed sequencing |
| mod_ok | output | 1 | Downstream modulo logic may act |
| wb_stb | output | 1 | Registered pointer write-back strobe |

## Verification
The main function is driven through a full 16-entry walk with pivot 8, feeding `ptr_next` back each step. This separates a true reverse-carry adder from a forward adder or a plain bit mirror. It also confirms the return to the aligned base. An 8-word walk from a base with many upper bits set shows that those bits are kept and that the wrap-around carry is dropped. Odd starting pointers separate LSB forcing from simple pass-through. Each single qualifying condition is then broken in turn (stack index, read, byte, non-incrementing mode, enable clear), with the enable left set where relevant, so that a missing term in the qualifying gate shows up as a bit-reversed result where a linear one is expected.

// File: rtl/brev_agen.sv
module brev_agen #(
  parameter int AW   = 16,
  parameter int SELW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_en,
  input  logic [AW-1:0]   ptr_in,
  input  logic [SELW-1:0] ptr_sel,
  input  logic [1:0]      amode,
  input  logic            wr,
  input  logic            word_sz,
  input  logic [AW-1:0]   ctl,
  input  logic            mod_en,
  output logic [AW-1:0]   ea,
  output logic [AW-1:0]   ptr_next,
  output logic            brev_act,
  output logic            mod_ok,
  output logic            wb_stb
);
  localparam logic [SELW-1:0] SP_SEL = '1;
  localparam logic [1:0] M_POST = 2'd1;
  localparam logic [1:0] M_PRE  = 2'd2;

  function automatic logic [AW-1:0] flip(input logic [AW-1:0] v);
    for (int i = 0; i < AW; i++) flip[i] = v[AW-1-i];
  endfunction

  logic          inc_mode, pre_mode;
  logic [AW-1:0] piv_b, rc_sum, lin_next, step;

  assign inc_mode = (amode == M_POST) || (amode == M_PRE);
  assign pre_mode = (amode == M_PRE);
  assign piv_b    = {ctl[AW-2:0], 1'b0};
  assign rc_sum   = flip(flip(ptr_in) + flip(piv_b));
  assign step     = word_sz ? AW'(2) : AW'(1);
  assign lin_next = inc_mode ? ptr_in + step : ptr_in;

  assign brev_act = ctl[AW-1] && (ptr_sel != SP_SEL) && inc_mode && wr && word_sz;
  assign mod_ok   = mod_en && !brev_act;

  assign ptr_next = brev_act ? {rc_sum[AW-1:1], 1'b0} : lin_next;
  assign ea       = pre_mode ? ptr_next
                  : (brev_act ? {ptr_in[AW-1:1], 1'b0} : ptr_in);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wb_stb <= 1'b0;
    else        wb_stb <= acc_en && inc_mode;

  // R1: stack pointer never qualifies (R6)
  a_r6_stack_excluded: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_sel == SP_SEL) |-> !brev_act);
  // R7
  a_r7_read_linear: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && amode == M_POST) |-> (ptr_next == ptr_in + step && ea == ptr_in));
  // R3
  a_r3_lsb_clear: assert property (@(posedge clk) disable iff (!rst_n)
    brev_act |-> (!ea[0] && !ptr_next[0]));
  // R4
  a_r4_pre_ea: assert property (@(posedge clk) disable iff (!rst_n)
    pre_mode |-> (ea == ptr_next));
  // R8
  a_r8_mod_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    brev_act |-> !mod_ok);
  // R9
  a_r9_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (brev_act && ctl[AW-2:4] == '0) |-> (ptr_next[AW-1:5] == ptr_in[AW-1:5]));
  // R10
  a_r10_strobe_set: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && inc_mode) |=> wb_stb);
  a_r10_strobe_clr: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |=> !wb_stb);
endmodule

// File: tb/sim_brev_agen.sv
module sim_brev_agen;
  logic        clk = 0, rst_n = 0, acc_en = 0, wr = 0, word_sz = 0, mod_en = 0;
  logic [15:0] ptr_in = 0, ctl = 0;
  logic [3:0]  ptr_sel = 0;
  logic [1:0]  amode = 0;
  logic [15:0] ea, ptr_next;
  logic        brev_act, mod_ok, wb_stb;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  brev_agen u0 (.clk(clk), .rst_n(rst_n), .acc_en(acc_en), .ptr_in(ptr_in),
    .ptr_sel(ptr_sel), .amode(amode), .wr(wr), .word_sz(word_sz), .ctl(ctl),
    .mod_en(mod_en), .ea(ea), .ptr_next(ptr_next), .brev_act(brev_act),
    .mod_ok(mod_ok), .wb_stb(wb_stb));

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int rev4(int k);
    int r = 0;
    for (int i = 0; i < 4; i++) if (k[i]) r |= 1 << (3 - i);
    return r;
  endfunction

  task automatic qual(logic [15:0] c, logic [15:0] p);
    ctl = c; ptr_in = p; ptr_sel = 4'd3; amode = 2'd1; wr = 1; word_sz = 1; mod_en = 0;
  endtask

  task automatic t_reset();
    check("R10 reset strobe", {15'd0, wb_stb}, 16'd0);
  endtask

  task automatic t_seq16();
    logic [15:0] base = 16'h0240;
    qual(16'h8008, base);
    for (int k = 0; k < 16; k++) begin
      #1;
      check("R1 qualify", {15'd0, brev_act}, 16'd1);
      check("R2 sequence", ea, base + 16'(2 * rev4(k)));
      ptr_in = ptr_next;
    end
    #1 check("R2 return to base", ptr_in, base);
  endtask

  task automatic t_pre_post();
    qual(16'h8008, 16'h0240); amode = 2'd2;
    #1 check("R4 pre ea", ea, 16'h0250);
    check("R4 pre next", ptr_next, 16'h0250);
    amode = 2'd1; ptr_in = 16'h0241;
    #1 check("R3 post ea lsb", ea, 16'h0240);
    check("R3 next lsb", ptr_next, 16'h0250);
    amode = 2'd2;
    #1 check("R3 pre ea lsb", ea, 16'h0250);
  endtask

  task automatic t_linear();
    qual(16'h0008, 16'h1000);
    #1 check("R5 post word ea", ea, 16'h1000);
    check("R5 post word next", ptr_next, 16'h1002);
    amode = 2'd2; word_sz = 0; ptr_in = 16'h1001;
    #1 check("R5 pre byte ea", ea, 16'h1002);
    check("R5 pre byte next", ptr_next, 16'h1002);
    amode = 2'd3; ptr_in = 16'h1235;
    #1 check("R5 offset mode ea", ea, 16'h1235);
    check("R5 offset mode next", ptr_next, 16'h1235);
  endtask

  task automatic t_stack();
    qual(16'h8008, 16'h0240); ptr_sel = 4'hF;
    #1 check("R6 stack next", ptr_next, 16'h0242);
    check("R6 stack act", {15'd0, brev_act}, 16'd0);
    ptr_sel = 4'hE;
    #1 check("R6 index 14 qualifies", ptr_next, 16'h0250);
  endtask

  task automatic t_nonqual();
    qual(16'h8008, 16'h0240); wr = 0;
    #1 check("R7 read", ptr_next, 16'h0242);
    wr = 1; word_sz = 0;
    #1 check("R7 byte", ptr_next, 16'h0241);
    word_sz = 1; amode = 2'd0;
    #1 check("R7 plain mode next", ptr_next, 16'h0240);
    check("R7 plain mode ea", ea, 16'h0240);
    amode = 2'd1; ctl = 16'h0008;
    #1 check("R1 enable clear", {15'd0, brev_act}, 16'd0);
  endtask

  task automatic t_mod();
    qual(16'h8008, 16'h0240); mod_en = 1;
    #1 check("R8 blocked", {15'd0, mod_ok}, 16'd0);
    check("R8 brev wins", ptr_next, 16'h0250);
    wr = 0;
    #1 check("R8 passes", {15'd0, mod_ok}, 16'd1);
  endtask

  task automatic t_upper();
    qual(16'h8004, 16'hABC0);
    for (int k = 0; k < 8; k++) begin
      #1 check("R9 upper kept", ptr_next & 16'hFFF0, 16'hABC0);
      ptr_in = ptr_next;
    end
    ptr_in = 16'hABCE;
    #1 check("R9 wrap drops carry", ptr_next, 16'hABC0);
  endtask

  task automatic t_strobe();
    @(negedge clk); acc_en = 1; amode = 2'd1;
    @(posedge clk); #1 check("R10 post strobe", {15'd0, wb_stb}, 16'd1);
    @(negedge clk); amode = 2'd2;
    @(posedge clk); #1 check("R10 pre strobe", {15'd0, wb_stb}, 16'd1);
    @(negedge clk); amode = 2'd3;
    @(posedge clk); #1 check("R10 offset no strobe", {15'd0, wb_stb}, 16'd0);
    @(negedge clk); acc_en = 0; amode = 2'd1;
    @(posedge clk); #1 check("R10 idle no strobe", {15'd0, wb_stb}, 16'd0);
  endtask

  initial begin
    #1 t_reset();
    #10 @(negedge clk) rst_n = 1;
    t_seq16();
    t_pre_post();
    t_linear();
    t_stack();
    t_nonqual();
    t_mod();
    t_upper();
    t_strobe();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule